// File: doc/BRIEF.md
# Banked Three-Port Vector Data Memory Front End

This block sits between the load/store units of a vector processor and a local memory split into banks. Each cycle it accepts up to two load requests and one store request, works out which bank each one needs, and lets every request whose bank is free proceed in that cycle. When two requests need the same bank, or when a narrow store needs a second access, the block raises one stall line for the whole datapath. All ports must then hold their requests until the stall falls. Requests that were already served during a stalled interval are not repeated.

A line is 256 bits (32 bytes). The bank is taken from the byte-address bits just above the line offset. Vector accesses move a whole line or an aligned half line. The first load port and the store port also take 32-, 16- and 8-bit scalar accesses. Stores of 8 and 16 bits read the line, merge in the new bytes and write it back, so they occupy their bank for two accesses. Load data comes back a fixed number of cycles after the request is served, whether or not the datapath is stalled at that time.

Top module: `vmem_tri_port`

## Requirements
- R1: Requests on load port 0, load port 1 and the store port that target three different banks are all served in the same cycle, and stall stays low.
- R2: The bank is byte-address bits [7:5] (8 banks). The row is the bits above them, and bits [4:0] are the byte offset within the 256-bit line.
- R3: Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 128-bit and 4 = 256-bit, and the byte offset must be a multiple of the size. Load data is the line shifted right by offset×8 and zero-extended above the access width, so a 128-bit load at offset 16 returns the upper half in bits [127:0].
- R4: An 8- or 16-bit store reads its line in one cycle and writes the merged line in the next. On its own it stalls for exactly one cycle. All other bytes of the line keep their values, and a load in a later bundle sees the new bytes.
- R5: Load data and its valid strobe appear in the fifth cycle after the cycle in which the load is served.
- R6: Among requests that need the same bank, load port 0 is served first, then load port 1, then the store. A load served before a same-address store in the same bundle returns the old data.
- R7: Stall stays high until every request of the held bundle has been served. Each request is served exactly once, so one load yields exactly one valid strobe.
- R8: An unknown size code, a misaligned offset, or a scalar size on load port 1 produces a one-cycle error pulse on that port's error output in the following cycle. No bank is accessed, a rejected store leaves memory unchanged, a rejected load produces no valid strobe, and the rejection does not raise the stall.
- R9: Stores of 32, 128 and 256 bits write only their own bytes in a single access and do not stall on their own.
- R10: After reset, stall, both valid strobes and all three error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld0_vld | input | 1 | Load port 0 request |
| ld0_addr | input | ADDR_W | Load port 0 byte address |
| ld0_size | input | 3 | Load port 0 size code |
| ld1_vld | input | 1 | Load port 1 request (vector only) |
| ld1_addr | input | ADDR_W | Load port 1 byte address |
| ld1_size | input | 3 | Load port 1 size code |
| st_vld | input | 1 | Store request |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 3 | Store size code |
| st_wdata | input | 256 | Store data, least significant bytes used |
| stall_o | output | 1 | Global datapath stall |
| ld0_rvalid | output | 1 | Load port 0 data valid |
| ld0_rdata | output | 256 | Load port 0 data |
| ld1_rvalid | output | 1 | Load port 1 data valid |
| ld1_rdata | output | 256 | Load port 1 data |
| ld0_err | output | 1 | Load port 0 request rejected |
| ld1_err | output | 1 | Load port 1 request rejected |
| st_err | output | 1 | Store request rejected |

## Verification
Bundles with all three ports on different banks show that full concurrency works and that the return latency is exact. Two-way and three-way collisions on one bank show that the priority order holds and that served requests are not repeated while the stall is held. Byte and halfword stores, each followed by a full-line load, show whether the read-modify-write keeps the neighbouring bytes. Word, half-line and line stores show that wide writes need only one access. Misaligned, unknown and port-1 scalar requests are checked to confirm they touch neither memory nor the stall.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  localparam int VLINE_W = 256;

  typedef enum logic [2:0] {
    SZ_B8   = 3'd0,
    SZ_B16  = 3'd1,
    SZ_B32  = 3'd2,
    SZ_V128 = 3'd3,
    SZ_V256 = 3'd4
  } vsize_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_WR = 1'b1} st_state_e;

  function automatic logic code_ok(input logic [2:0] s);
    return s <= 3'd4;
  endfunction

  function automatic int unsigned nbytes(input logic [2:0] s);
    case (s)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_sub(input logic [2:0] s);
    return s < 3'd2;
  endfunction

  function automatic logic is_scalar(input logic [2:0] s);
    return s < 3'd3;
  endfunction

  function automatic logic [VLINE_W-1:0] size_mask(input logic [2:0] s);
    logic [VLINE_W-1:0] m;
    m = '1;
    if (s != 3'd4) m = m >> (VLINE_W - 8 * nbytes(s));
    return m;
  endfunction
endpackage

// File: rtl/vmem_bank.sv
module vmem_bank #(
  parameter int ROW_W = 3,
  parameter int DW    = 256
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DW-1:0]     wdata,
  input  logic [DW/8-1:0]   wbe,
  output logic [DW-1:0]     rdata
);
  localparam int ROWS = 1 << ROW_W;
  localparam int NBY  = DW / 8;

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < NBY; i++) begin
          if (wbe[i]) mem[row][i*8 +: 8] <= wdata[i*8 +: 8];
        end
      end else begin
        rdata <= mem[row];
      end
    end
  end
endmodule

// File: rtl/vmem_arb.sv
module vmem_arb #(
  parameter int NBANK = 8,
  parameter int BW    = 3
) (
  input  logic [2:0]     act,
  input  logic [BW-1:0]  bank [3],
  input  logic           hold_vld,
  input  logic [BW-1:0]  hold_bank,
  output logic [2:0]     win
);
  logic [NBANK-1:0] taken;

  always_comb begin
    taken = '0;
    if (hold_vld) taken[hold_bank] = 1'b1;
    for (int p = 0; p < 3; p++) begin
      win[p] = act[p] && !taken[bank[p]];
      if (win[p]) taken[bank[p]] = 1'b1;
    end
  end
endmodule

// File: rtl/vmem_ld_pipe.sv
module vmem_ld_pipe
  import vmem_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int BW    = 3,
  parameter int LAT   = 5,
  parameter int DW    = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     issue,
  input  logic [$clog2(DW/8)-1:0]  off,
  input  logic [2:0]               size,
  input  logic [BW-1:0]            bank,
  input  logic [DW-1:0]            bank_q [NBANK],
  output logic                     rvalid,
  output logic [DW-1:0]            rdata
);
  localparam int OFF_W = $clog2(DW/8);
  localparam int NST   = LAT - 1;

  logic             v1;
  logic [OFF_W-1:0] off1;
  logic [2:0]       size1;
  logic [BW-1:0]    bank1;
  logic [DW-1:0]    line, fmt;
  logic             vp [NST];
  logic [DW-1:0]    dp [NST];

  // stage 1 is the bank's own output register; format it here
  always_comb begin
    line = bank_q[bank1];
    fmt  = (line >> {off1, 3'b000}) & size_mask(size1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      for (int j = 0; j < NST; j++) vp[j] <= 1'b0;
    end else begin
      v1    <= issue;
      vp[0] <= v1;
      for (int j = 1; j < NST; j++) vp[j] <= vp[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      off1  <= off;
      size1 <= size;
      bank1 <= bank;
    end
    if (v1) dp[0] <= fmt;
    for (int j = 1; j < NST; j++) begin
      if (vp[j-1]) dp[j] <= dp[j-1];
    end
  end

  assign rvalid = vp[NST-1];
  assign rdata  = dp[NST-1];
endmodule

// File: rtl/vmem_tri_port.sv
module vmem_tri_port
  import vmem_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 11,
  parameter int RD_LAT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld0_vld,
  input  logic [ADDR_W-1:0]  ld0_addr,
  input  logic [2:0]         ld0_size,
  input  logic               ld1_vld,
  input  logic [ADDR_W-1:0]  ld1_addr,
  input  logic [2:0]         ld1_size,
  input  logic               st_vld,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [2:0]         st_size,
  input  logic [255:0]       st_wdata,
  output logic               stall_o,
  output logic               ld0_rvalid,
  output logic [255:0]       ld0_rdata,
  output logic               ld1_rvalid,
  output logic [255:0]       ld1_rdata,
  output logic               ld0_err,
  output logic               ld1_err,
  output logic               st_err
);
  localparam int DW    = VLINE_W;
  localparam int LB    = DW / 8;
  localparam int OFF_W = $clog2(LB);
  localparam int BW    = $clog2(NBANK);
  localparam int ROW_W = ADDR_W - OFF_W - BW;

  // port 0 = load 0, port 1 = load 1, port 2 = store
  logic [2:0]        vld;
  logic [ADDR_W-1:0] addr [3];
  logic [2:0]        size [3];
  logic [OFF_W-1:0]  off  [3];
  logic [BW-1:0]     bank [3];
  logic [ROW_W-1:0]  row  [3];
  logic [2:0]        bad, live, act, errnow, win, fin, pend;
  logic [2:0]        done_q, done_n, err_q;
  st_state_e         st_q, st_n;
  logic              st_sub, rmw_wr, rmw_start;

  logic [BW-1:0]     rmw_bank;
  logic [ROW_W-1:0]  rmw_row;
  logic [DW-1:0]     rmw_data, rmw_bits, merged;
  logic [LB-1:0]     st_be;
  logic [DW-1:0]     st_bits, st_wsh;
  logic [DW-1:0]     bank_q [NBANK];

  assign vld     = {st_vld, ld1_vld, ld0_vld};
  assign addr[0] = ld0_addr;
  assign addr[1] = ld1_addr;
  assign addr[2] = st_addr;
  assign size[0] = ld0_size;
  assign size[1] = ld1_size;
  assign size[2] = st_size;

  // ---------------- request decode ----------------
  for (genvar p = 0; p < 3; p++) begin : g_dec
    localparam bit SCALAR_OK = (p != 1);
    assign off[p]  = addr[p][OFF_W-1:0];
    assign bank[p] = addr[p][OFF_W +: BW];
    assign row[p]  = addr[p][ADDR_W-1 -: ROW_W];
    assign bad[p]  = !code_ok(size[p])
                   || ((32'(off[p]) & (nbytes(size[p]) - 1)) != 0)
                   || (!SCALAR_OK && is_scalar(size[p]));
    assign live[p]   = vld[p] && !done_q[p];
    assign errnow[p] = live[p] && bad[p];
  end

  assign rmw_wr = (st_q == ST_WR);
  assign act[0] = live[0] && !bad[0];
  assign act[1] = live[1] && !bad[1];
  assign act[2] = live[2] && !bad[2] && !rmw_wr;

  vmem_arb #(.NBANK(NBANK), .BW(BW)) u_arb (
    .act       (act),
    .bank      (bank),
    .hold_vld  (rmw_wr),
    .hold_bank (rmw_bank),
    .win       (win)
  );

  // ---------------- completion and stall ----------------
  assign st_sub    = is_sub(size[2]);
  assign rmw_start = win[2] && st_sub;
  assign fin[0]    = win[0] || errnow[0];
  assign fin[1]    = win[1] || errnow[1];
  assign fin[2]    = rmw_wr || (win[2] && !st_sub) || errnow[2];
  assign pend      = live & ~fin;
  assign stall_o   = |pend;

  always_comb begin
    done_n = stall_o ? (done_q | fin) : 3'b000;
    st_n   = st_q;
    case (st_q)
      ST_IDLE: if (rmw_start) st_n = ST_WR;
      ST_WR:   st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 3'b000;
      st_q   <= ST_IDLE;
      err_q  <= 3'b000;
    end else begin
      done_q <= done_n;
      st_q   <= st_n;
      err_q  <= errnow;
    end
  end

  // ---------------- store data placement ----------------
  always_comb begin
    for (int i = 0; i < LB; i++) begin
      st_be[i] = (i >= int'(off[2])) && (i < int'(off[2]) + int'(nbytes(size[2])));
    end
  end

  for (genvar i = 0; i < LB; i++) begin : g_bits
    assign st_bits[i*8 +: 8] = {8{st_be[i]}};
  end

  assign st_wsh = st_wdata << {off[2], 3'b000};

  always_ff @(posedge clk) begin
    if (rmw_start) begin
      rmw_bank <= bank[2];
      rmw_row  <= row[2];
      rmw_data <= st_wsh;
      rmw_bits <= st_bits;
    end
  end

  assign merged = (bank_q[rmw_bank] & ~rmw_bits) | (rmw_data & rmw_bits);

  // ---------------- bank array ----------------
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic s_h, s0, s1, s2, en, we;
    logic [ROW_W-1:0] brow;
    logic [DW-1:0]    bwd;
    logic [LB-1:0]    bbe;

    assign s_h  = rmw_wr && (rmw_bank == BW'(b));
    assign s0   = win[0] && (bank[0] == BW'(b));
    assign s1   = win[1] && (bank[1] == BW'(b));
    assign s2   = win[2] && (bank[2] == BW'(b));
    assign en   = s_h || s0 || s1 || s2;
    assign we   = s_h || (s2 && !st_sub);
    assign brow = s_h ? rmw_row : s0 ? row[0] : s1 ? row[1] : row[2];
    assign bwd  = s_h ? merged : st_wsh;
    assign bbe  = s_h ? {LB{1'b1}} : st_be;

    vmem_bank #(.ROW_W(ROW_W), .DW(DW)) u_bank (
      .clk   (clk),
      .en    (en),
      .we    (we),
      .row   (brow),
      .wdata (bwd),
      .wbe   (bbe),
      .rdata (bank_q[b])
    );

    // R6: each bank has at most one user per cycle
    a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({s_h, s0, s1, s2}) <= 1);
  end

  // ---------------- load return paths ----------------
  vmem_ld_pipe #(.NBANK(NBANK), .BW(BW), .LAT(RD_LAT), .DW(DW)) u_ld0 (
    .clk(clk), .rst_n(rst_n), .issue(win[0]), .off(off[0]), .size(size[0]),
    .bank(bank[0]), .bank_q(bank_q), .rvalid(ld0_rvalid), .rdata(ld0_rdata)
  );

  vmem_ld_pipe #(.NBANK(NBANK), .BW(BW), .LAT(RD_LAT), .DW(DW)) u_ld1 (
    .clk(clk), .rst_n(rst_n), .issue(win[1]), .off(off[1]), .size(size[1]),
    .bank(bank[1]), .bank_q(bank_q), .rvalid(ld1_rvalid), .rdata(ld1_rdata)
  );

  assign ld0_err = err_q[0];
  assign ld1_err = err_q[1];
  assign st_err  = err_q[2];

  // ---------------- assertions ----------------
  // R4: the read phase of a narrow store is followed by its write phase
  a_r4_rmw_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> (rmw_wr && rmw_row == $past(row[2])));

  // R7: two live loads on one bank must stall the datapath
  a_r7_conflict_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && act[1] && bank[0] == bank[1]) |-> stall_o);

  // R8: a rejected request is never granted a bank
  a_r8_err_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (errnow & win) == 3'b000);

  // R8: a rejection alone never holds the stall
  a_r8_err_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((live & ~errnow) == 3'b000) |-> !stall_o);
endmodule

// File: tb/vmem_tri_port_bench.sv
module vmem_tri_port_bench;
  localparam int AW = 11;

  logic clk, rst_n;
  logic ld0_vld, ld1_vld, st_vld;
  logic [AW-1:0] ld0_addr, ld1_addr, st_addr;
  logic [2:0] ld0_size, ld1_size, st_size;
  logic [255:0] st_wdata;
  logic stall_o, ld0_rvalid, ld1_rvalid, ld0_err, ld1_err, st_err;
  logic [255:0] ld0_rdata, ld1_rdata;

  int checks = 0, errors = 0, cyc = 0;
  int rcnt [2];
  int rcyc [2];
  logic [255:0] rdat [2];
  logic [255:0] shadow [64];

  vmem_tri_port u_vmem_tri_port (
    .clk(clk), .rst_n(rst_n),
    .ld0_vld(ld0_vld), .ld0_addr(ld0_addr), .ld0_size(ld0_size),
    .ld1_vld(ld1_vld), .ld1_addr(ld1_addr), .ld1_size(ld1_size),
    .st_vld(st_vld), .st_addr(st_addr), .st_size(st_size), .st_wdata(st_wdata),
    .stall_o(stall_o),
    .ld0_rvalid(ld0_rvalid), .ld0_rdata(ld0_rdata),
    .ld1_rvalid(ld1_rvalid), .ld1_rdata(ld1_rdata),
    .ld0_err(ld0_err), .ld1_err(ld1_err), .st_err(st_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    rcnt[0] = 0; rcnt[1] = 0;
  end

  always @(negedge clk) begin
    if (ld0_rvalid) begin rcnt[0]++; rcyc[0] = cyc; rdat[0] = ld0_rdata; end
    if (ld1_rvalid) begin rcnt[1]++; rcyc[1] = cyc; rdat[1] = ld1_rdata; end
  end

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] msk(input logic [2:0] s);
    case (s)
      3'd0: return 256'hFF;
      3'd1: return 256'hFFFF;
      3'd2: return 256'hFFFF_FFFF;
      3'd3: return {128'd0, {128{1'b1}}};
      default: return {256{1'b1}};
    endcase
  endfunction

  function automatic int szb(input logic [2:0] s);
    case (s)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;
      3'd3: return 16; default: return 32;
    endcase
  endfunction

  function automatic logic [255:0] exp_ld(input logic [AW-1:0] a, input logic [2:0] s);
    return (shadow[a[10:5]] >> (int'(a[4:0]) * 8)) & msk(s);
  endfunction

  task automatic shadow_st(input logic [AW-1:0] a, input logic [2:0] s, input logic [255:0] d);
    for (int i = 0; i < szb(s); i++)
      shadow[a[10:5]][(int'(a[4:0]) + i) * 8 +: 8] = d[i*8 +: 8];
  endtask

  // drive one bundle, hold it through the stall, return stall cycles and error bits
  task automatic bundle(input logic v0, input logic [AW-1:0] a0, input logic [2:0] z0,
                        input logic v1, input logic [AW-1:0] a1, input logic [2:0] z1,
                        input logic vs, input logic [AW-1:0] as_, input logic [2:0] zs,
                        input logic [255:0] wd,
                        output int nst, output int t0, output logic [2:0] errs);
    @(negedge clk);
    ld0_vld = v0; ld0_addr = a0; ld0_size = z0;
    ld1_vld = v1; ld1_addr = a1; ld1_size = z1;
    st_vld = vs; st_addr = as_; st_size = zs; st_wdata = wd;
    t0 = cyc;
    #1;
    nst = 0;
    while (stall_o) begin
      @(negedge clk); #1; nst++;
    end
    @(negedge clk);
    errs = {st_err, ld1_err, ld0_err};
    ld0_vld = 1'b0; ld1_vld = 1'b0; st_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [2:0] s, input logic [255:0] d,
                          input int exp_nst, input string req);
    int nst, t0; logic [2:0] e;
    bundle(0, 0, 4, 0, 0, 4, 1, a, s, d, nst, t0, e);
    shadow_st(a, s, d);
    check(req, 256'(nst), 256'(exp_nst));
  endtask

  task automatic do_load(input int p, input logic [AW-1:0] a, input logic [2:0] s, input string req);
    int nst, t0, c0; logic [2:0] e;
    c0 = rcnt[p];
    if (p == 0) bundle(1, a, s, 0, 0, 4, 0, 0, 4, '0, nst, t0, e);
    else        bundle(0, 0, 4, 1, a, s, 0, 0, 4, '0, nst, t0, e);
    idle(7);
    check({req, " data"}, rdat[p], exp_ld(a, s));
    check("R5 latency", 256'(rcyc[p] - t0), 256'd5);
    check("R7 one strobe", 256'(rcnt[p] - c0), 256'd1);
  endtask

  task automatic t_reset;
    check("R10 reset outputs",
          256'({stall_o, ld0_rvalid, ld1_rvalid, ld0_err, ld1_err, st_err}), 256'd0);
  endtask

  task automatic t_fill;
    do_store(11'h000, 3'd4, {8{32'h1000_0000}} + 256'h0123, 0, "R9 line store no stall");
    do_store(11'h020, 3'd4, {8{32'h2222_1111}}, 0, "R9 line store no stall");
    do_store(11'h040, 3'd4, {8{32'h4444_3333}}, 0, "R9 line store no stall");
    do_store(11'h100, 3'd4, {8{32'h5555_6666}}, 0, "R9 line store no stall");
    do_load(1, 11'h000, 3'd4, "R2 bank0 row0");
    do_load(1, 11'h100, 3'd4, "R2 bank0 row1");
  endtask

  task automatic t_parallel;
    int nst, t0; logic [2:0] e;
    logic [255:0] d = {8{32'hCAFE_0042}};
    logic [255:0] e0, e1;
    e0 = exp_ld(11'h000, 3'd4);
    e1 = exp_ld(11'h020, 3'd4);
    bundle(1, 11'h000, 3'd4, 1, 11'h020, 3'd4, 1, 11'h040, 3'd4, d, nst, t0, e);
    shadow_st(11'h040, 3'd4, d);
    check("R1 no stall on distinct banks", 256'(nst), 256'd0);
    idle(7);
    check("R1 port0 data", rdat[0], e0);
    check("R1 port1 data", rdat[1], e1);
    check("R5 port0 latency", 256'(rcyc[0] - t0), 256'd5);
    check("R5 port1 latency", 256'(rcyc[1] - t0), 256'd5);
    do_load(0, 11'h040, 3'd4, "R1 store landed");
  endtask

  task automatic t_conflict2;
    int nst, t0, c0, c1; logic [2:0] e;
    c0 = rcnt[0]; c1 = rcnt[1];
    bundle(1, 11'h000, 3'd4, 1, 11'h100, 3'd4, 0, 0, 4, '0, nst, t0, e);
    check("R6 two-load conflict stall", 256'(nst), 256'd1);
    idle(8);
    check("R6 port0 first", 256'(rcyc[0] - t0), 256'd5);
    check("R6 port1 second", 256'(rcyc[1] - t0), 256'd6);
    check("R6 port1 data", rdat[1], exp_ld(11'h100, 3'd4));
    check("R7 single strobe each", 256'({rcnt[0] - c0, rcnt[1] - c1}), 256'({32'd1, 32'd1}));
  endtask

  task automatic t_conflict3;
    int nst, t0; logic [2:0] e;
    logic [255:0] old0, d;
    d = {4{64'hBEEF_0000_F00D_7777}};
    old0 = exp_ld(11'h000, 3'd4);
    bundle(1, 11'h000, 3'd4, 1, 11'h100, 3'd4, 1, 11'h000, 3'd4, d, nst, t0, e);
    shadow_st(11'h000, 3'd4, d);
    check("R7 three-way stall length", 256'(nst), 256'd2);
    idle(8);
    check("R6 load before store sees old", rdat[0], old0);
    check("R6 port1 served second", 256'(rcyc[1] - t0), 256'd6);
    do_load(0, 11'h000, 3'd4, "R6 store served last");
  endtask

  task automatic t_rmw;
    int nst, t0; logic [2:0] e;
    do_store(11'h045, 3'd0, 256'hA5, 1, "R4 byte store stalls one");
    do_load(1, 11'h040, 3'd4, "R4 byte merge");
    do_store(11'h04A, 3'd1, 256'h9C3E, 1, "R4 half store stalls one");
    do_load(1, 11'h040, 3'd4, "R4 half merge");
    // narrow store alongside a load on another bank
    bundle(1, 11'h020, 3'd4, 0, 0, 4, 1, 11'h05F, 3'd0, 256'h7B, nst, t0, e);
    shadow_st(11'h05F, 3'd0, 256'h7B);
    check("R4 stall with parallel load", 256'(nst), 256'd1);
    idle(7);
    check("R4 parallel load data", rdat[0], exp_ld(11'h020, 3'd4));
    do_load(1, 11'h040, 3'd4, "R4 top byte merge");
  endtask

  task automatic t_sizes;
    do_load(0, 11'h050, 3'd3, "R3 upper half");
    do_load(0, 11'h040, 3'd3, "R3 lower half");
    do_load(0, 11'h044, 3'd2, "R3 word");
    do_load(0, 11'h045, 3'd0, "R3 byte");
    do_load(0, 11'h04A, 3'd1, "R3 half");
    do_store(11'h028, 3'd2, 256'hD00D_FEED, 0, "R9 word store no stall");
    do_store(11'h030, 3'd3, {4{32'h0BAD_F00D}}, 0, "R9 half-line store no stall");
    do_load(1, 11'h020, 3'd4, "R9 wide writes keep neighbours");
  endtask

  task automatic t_errors;
    int nst, t0, c1, c0; logic [2:0] e;
    c1 = rcnt[1];
    bundle(0, 0, 4, 1, 11'h040, 3'd0, 0, 0, 4, '0, nst, t0, e);
    check("R8 scalar on port1 flagged", 256'({e, 32'(nst)}), 256'({3'b010, 32'd0}));
    idle(7);
    check("R8 port1 no strobe", 256'(rcnt[1] - c1), 256'd0);
    bundle(0, 0, 4, 0, 0, 4, 1, 11'h044, 3'd4, {8{32'hFFFF_FFFF}}, nst, t0, e);
    check("R8 misaligned store flagged", 256'({e, 32'(nst)}), 256'({3'b100, 32'd0}));
    do_load(1, 11'h040, 3'd4, "R8 memory untouched");
    c0 = rcnt[0];
    bundle(1, 11'h048, 3'd3, 0, 0, 4, 1, 11'h020, 3'd7, '1, nst, t0, e);
    check("R8 misaligned half and bad code", 256'({e, 32'(nst)}), 256'({3'b101, 32'd0}));
    idle(7);
    check("R8 port0 no strobe", 256'(rcnt[0] - c0), 256'd0);
    do_load(0, 11'h020, 3'd4, "R8 bad-code store no write");
  endtask

  initial begin
    rst_n = 1'b0;
    ld0_vld = 0; ld1_vld = 0; st_vld = 0;
    ld0_addr = '0; ld1_addr = '0; st_addr = '0;
    ld0_size = 3'd4; ld1_size = 3'd4; st_size = 3'd4; st_wdata = '0;
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_fill();
    t_parallel();
    t_conflict2();
    t_conflict3();
    t_rmw();
    t_sizes();
    t_errors();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule